// File: doc/BRIEF.md
# System-to-Peripheral Bus Bridge with Narrow-Write Widening

The bridge accepts single 32-bit transfers from a system-side requester and carries each one out as an APB transfer on one of two peripheral ports. Both ports run at a rate derived from the system clock. Each port has its own clock-enable divider, and its ratio is selected at run time as a power of two from 1 to 16. Nothing crosses between clock domains: every flop is on the system clock, and each APB phase advances only on cycles where the chosen port's enable tick is high.

The peripheral side only ever sees full-word accesses. A byte or halfword write picks its value from the byte lane given by the low address bits. That value is then repeated across all 32 bits of the APB write data. A read of any size returns the whole 32-bit word, and the requester selects its own lane. The system side is held off with a low ready for the whole transfer. Completion is signalled by a one-cycle done pulse that carries the read data and any slave error.

Address bit `PORT_BIT` steers a request to port 0 or port 1. Only that port's select is driven. The address, write data and direction buses are shared by both ports.

Top module: `sysbus_to_pbus_bridge`

## Requirements
- R1: While reset is held and just after it, sys_ready is 1, sys_done is 0, and psel0, penable0, psel1 and penable1 are all 0.
- R2: sys_addr bit PORT_BIT (default 16) picks the port: 0 selects port 0 and 1 selects port 1. Only the chosen port's psel is ever high, and the other port's psel stays 0.
- R3: Each transfer has exactly one SETUP period with psel=1 and penable=0, followed by ACCESS with psel=1 and penable=1. paddr, pwrite and pwdata hold steady through ACCESS.
- R4: APB phase changes happen only on the selected port's divider tick. The ratio is 2^div_sel, and a div_sel above 4 acts as 4. With zero wait states, psel is high for exactly 2×ratio system cycles.
- R5: ACCESS lasts until pready is high on a tick. With the slave adding w wait periods, psel is high for (w+2)×ratio cycles.
- R6: sys_ready is 0 from the cycle after a request is accepted until completion. sys_done is a one-cycle pulse, and sys_ready is 1 in that same cycle.
- R7: A write with sys_size=0 (byte) takes the byte in lane sys_addr[1:0] of sys_wdata and drives it on all four byte lanes of pwdata.
- R8: A write with sys_size=1 (halfword) takes the halfword in lane sys_addr[1] of sys_wdata and drives it on both halves of pwdata.
- R9: A write with sys_size=2 or 3 passes sys_wdata unchanged. paddr always equals sys_addr[PADDR_W-1:0] with its two low bits cleared.
- R10: A read (pwrite=0) of any size returns the full prdata word of the selected port on sys_rdata during sys_done. A write completion returns 0.
- R11: sys_err during sys_done equals the pslverr value of the selected port on the completing ACCESS tick.
- R12: The two ports divide independently. Each port's timing follows only its own div_sel input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| div_sel0 | input | SEL_W | Port 0 ratio exponent (ratio 2^n, capped at 16) |
| div_sel1 | input | SEL_W | Port 1 ratio exponent |
| sys_valid | input | 1 | Request present; taken when sys_ready is 1 |
| sys_addr | input | ADDR_W | Request byte address |
| sys_write | input | 1 | 1 = write, 0 = read |
| sys_size | input | 2 | 0 byte, 1 halfword, 2/3 word |
| sys_wdata | input | 32 | Write data in lane-aligned position |
| sys_ready | output | 1 | Bridge idle and able to take a request |
| sys_done | output | 1 | One-cycle completion pulse |
| sys_rdata | output | 32 | Read word, valid with sys_done |
| sys_err | output | 1 | Error response, valid with sys_done |
| paddr | output | PADDR_W | Shared word-aligned peripheral address |
| pwrite | output | 1 | Shared transfer direction |
| pwdata | output | 32 | Shared widened write data |
| psel0 | output | 1 | Port 0 select |
| penable0 | output | 1 | Port 0 enable |
| pready0 | input | 1 | Port 0 ready |
| prdata0 | input | 32 | Port 0 read data |
| pslverr0 | input | 1 | Port 0 slave error |
| psel1 | output | 1 | Port 1 select |
| penable1 | output | 1 | Port 1 enable |
| pready1 | input | 1 | Port 1 ready |
| prdata1 | input | 32 | Port 1 read data |
| pslverr1 | input | 1 | Port 1 slave error |

## Verification
The bench writes byte data into each of the four lanes and halfword data into both halves. A bridge that took its byte from lane 0, or passed the narrow value through unreplicated, would put the wrong pwdata on the bus. It measures the psel width in system cycles at ratios 1, 2, 4, 8 and 16, with a capped exponent of 7, with the two ports at different settings and with slave wait states. Phases that ignored the tick, or ran from the wrong port's divider, would show up as a wrong width. It injects a slave error on a write and on a read, then follows each with a clean transfer, which catches an error flag that is dropped or left set. It also checks that reads return the full word and that the unselected port stays quiet.

// File: rtl/pbr_pkg.sv
package pbr_pkg;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_WIDE = 2'd3
    } xfer_size_e;

    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_PEND   = 2'd1,
        PH_SETUP  = 2'd2,
        PH_ACCESS = 2'd3
    } phase_e;

endpackage

// File: rtl/pbr_tick_gen.sv
module pbr_tick_gen #(
    parameter int SEL_W    = 3,
    parameter int MAX_LOG2 = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SEL_W-1:0] div_sel,
    output logic             tick
);
    localparam int CNT_W = (MAX_LOG2 < 1) ? 1 : MAX_LOG2;

    logic [CNT_W-1:0] cnt_d, cnt_q;
    logic [CNT_W-1:0] mask;
    logic [SEL_W-1:0] eff_sel;

    always_comb begin
        eff_sel = (div_sel > SEL_W'(MAX_LOG2)) ? SEL_W'(MAX_LOG2) : div_sel;
        for (int i = 0; i < CNT_W; i++) begin
            mask[i] = (int'(eff_sel) > i);
        end
        tick  = ((cnt_q & mask) == mask);
        cnt_d = (cnt_q + CNT_W'(1)) & mask;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

endmodule

// File: rtl/pbr_lane_fill.sv
module pbr_lane_fill
    import pbr_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  xfer_size_e              size,
    input  logic [$clog2(DATA_W/8)-1:0] lane,
    input  logic [DATA_W-1:0]       din,
    output logic [DATA_W-1:0]       dout
);
    localparam int BYTES  = DATA_W / 8;
    localparam int LANE_W = $clog2(BYTES);

    logic [7:0]  sel_byte;
    logic [15:0] sel_half;

    always_comb begin
        sel_byte = din[8*lane +: 8];
        sel_half = din[16*lane[LANE_W-1] +: 16];
    end

    for (genvar g = 0; g < BYTES; g++) begin : g_lane
        always_comb begin
            unique case (size)
                SZ_BYTE: dout[g*8 +: 8] = sel_byte;
                SZ_HALF: dout[g*8 +: 8] = sel_half[(g%2)*8 +: 8];
                default: dout[g*8 +: 8] = din[g*8 +: 8];
            endcase
        end
    end

endmodule

// File: rtl/sysbus_to_pbus_bridge.sv
module sysbus_to_pbus_bridge
    import pbr_pkg::*;
#(
    parameter int ADDR_W   = 32,
    parameter int PADDR_W  = 16,
    parameter int PORT_BIT = 16,
    parameter int SEL_W    = 3,
    parameter int MAX_LOG2 = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [SEL_W-1:0]   div_sel0,
    input  logic [SEL_W-1:0]   div_sel1,
    input  logic               sys_valid,
    input  logic [ADDR_W-1:0]  sys_addr,
    input  logic               sys_write,
    input  logic [1:0]         sys_size,
    input  logic [31:0]        sys_wdata,
    output logic               sys_ready,
    output logic               sys_done,
    output logic [31:0]        sys_rdata,
    output logic               sys_err,
    output logic [PADDR_W-1:0] paddr,
    output logic               pwrite,
    output logic [31:0]        pwdata,
    output logic               psel0,
    output logic               penable0,
    input  logic               pready0,
    input  logic [31:0]        prdata0,
    input  logic               pslverr0,
    output logic               psel1,
    output logic               penable1,
    input  logic               pready1,
    input  logic [31:0]        prdata1,
    input  logic               pslverr1
);
    localparam int DATA_W  = 32;
    localparam int N_PORTS = 2;

    typedef struct packed {
        phase_e              phase;
        logic                port;
        logic [PADDR_W-1:0]  addr;
        logic                write;
        logic [DATA_W-1:0]   wdata;
        logic                done;
        logic [DATA_W-1:0]   rdata;
        logic                err;
    } bridge_state_t;

    bridge_state_t st_d, st_q;

    logic [SEL_W-1:0]  div_sel_a [N_PORTS];
    logic [DATA_W-1:0] prdata_a  [N_PORTS];
    logic [N_PORTS-1:0] tick, pready_a, pslverr_a, psel_a, penable_a;
    logic [DATA_W-1:0] filled_wdata;

    assign div_sel_a[0] = div_sel0;
    assign div_sel_a[1] = div_sel1;
    assign prdata_a[0]  = prdata0;
    assign prdata_a[1]  = prdata1;
    assign pready_a     = {pready1, pready0};
    assign pslverr_a    = {pslverr1, pslverr0};

    for (genvar p = 0; p < N_PORTS; p++) begin : g_div
        pbr_tick_gen #(
            .SEL_W    (SEL_W),
            .MAX_LOG2 (MAX_LOG2)
        ) u_tick (
            .clk     (clk),
            .rst_n   (rst_n),
            .div_sel (div_sel_a[p]),
            .tick    (tick[p])
        );
    end

    pbr_lane_fill #(
        .DATA_W (DATA_W)
    ) u_fill (
        .size (xfer_size_e'(sys_size)),
        .lane (sys_addr[1:0]),
        .din  (sys_wdata),
        .dout (filled_wdata)
    );

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        unique case (st_q.phase)
            PH_IDLE: begin
                if (sys_valid) begin
                    st_d.phase = PH_PEND;
                    st_d.port  = sys_addr[PORT_BIT];
                    st_d.addr  = {sys_addr[PADDR_W-1:2], 2'b00};
                    st_d.write = sys_write;
                    st_d.wdata = filled_wdata;
                end
            end
            PH_PEND: begin
                if (tick[st_q.port]) st_d.phase = PH_SETUP;
            end
            PH_SETUP: begin
                if (tick[st_q.port]) st_d.phase = PH_ACCESS;
            end
            PH_ACCESS: begin
                if (tick[st_q.port] && pready_a[st_q.port]) begin
                    st_d.phase = PH_IDLE;
                    st_d.done  = 1'b1;
                    st_d.rdata = st_q.write ? '0 : prdata_a[st_q.port];
                    st_d.err   = pslverr_a[st_q.port];
                end
            end
            default: st_d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{phase: PH_IDLE, port: 1'b0, addr: '0, write: 1'b0,
                      wdata: '0, done: 1'b0, rdata: '0, err: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    for (genvar p = 0; p < N_PORTS; p++) begin : g_sel
        always_comb begin
            psel_a[p]    = (st_q.port == 1'(p)) &&
                           ((st_q.phase == PH_SETUP) || (st_q.phase == PH_ACCESS));
            penable_a[p] = (st_q.port == 1'(p)) && (st_q.phase == PH_ACCESS);
        end
    end

    assign psel0     = psel_a[0];
    assign penable0  = penable_a[0];
    assign psel1     = psel_a[1];
    assign penable1  = penable_a[1];
    assign paddr     = st_q.addr;
    assign pwrite    = st_q.write;
    assign pwdata    = st_q.wdata;
    assign sys_ready = (st_q.phase == PH_IDLE);
    assign sys_done  = st_q.done;
    assign sys_rdata = st_q.rdata;
    assign sys_err   = st_q.err;

endmodule

// File: rtl/pbr_bridge_chk.sv
module pbr_bridge_chk #(
    parameter int PADDR_W = 16
) (
    input logic               clk,
    input logic               rst_n,
    input logic               tick0,
    input logic               tick1,
    input logic               psel0,
    input logic               penable0,
    input logic               psel1,
    input logic               penable1,
    input logic [PADDR_W-1:0] paddr,
    input logic [31:0]        pwdata,
    input logic               pwrite,
    input logic               sys_ready,
    input logic               sys_done
);
    p_one_port_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({psel1, psel0}));

    p_enable_in_sel_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (penable0 |-> psel0) and (penable1 |-> psel1));

    p_setup_first0_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(psel0) |-> !penable0);

    p_setup_first1_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(psel1) |-> !penable1);

    p_hold_access_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ((psel0 && penable0) || (psel1 && penable1)) |->
            ($stable(paddr) && $stable(pwdata) && $stable(pwrite)));

    p_tick_gate0_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(psel0) || !$stable(penable0)) |-> $past(tick0));

    p_tick_gate1_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(psel1) || !$stable(penable1)) |-> $past(tick1));

    p_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (psel0 || psel1) |-> !sys_ready);

    p_done_ready_r6: assert property (@(posedge clk) disable iff (!rst_n)
        sys_done |-> sys_ready);

    p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        sys_done |=> !sys_done);

endmodule

bind sysbus_to_pbus_bridge pbr_bridge_chk #(
    .PADDR_W (PADDR_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick0     (tick[0]),
    .tick1     (tick[1]),
    .psel0     (psel0),
    .penable0  (penable0),
    .psel1     (psel1),
    .penable1  (penable1),
    .paddr     (paddr),
    .pwdata    (pwdata),
    .pwrite    (pwrite),
    .sys_ready (sys_ready),
    .sys_done  (sys_done)
);

// File: tb/sysbus_to_pbus_bridge_bench.sv
module sysbus_to_pbus_bridge_bench;

    typedef struct {
        int          port;
        logic [15:0] addr;
        logic        wr;
        logic [31:0] wdata;
        int          width;
        string       req;
    } apb_item_t;

    typedef struct {
        logic [31:0] rdata;
        logic        err;
        string       req;
    } rsp_item_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [2:0] div_sel0 = 3'd0, div_sel1 = 3'd0;
    logic sys_valid = 1'b0;
    logic [31:0] sys_addr = '0;
    logic sys_write = 1'b0;
    logic [1:0] sys_size = 2'd2;
    logic [31:0] sys_wdata = '0;
    logic sys_ready, sys_done, sys_err;
    logic [31:0] sys_rdata;
    logic [15:0] paddr;
    logic pwrite;
    logic [31:0] pwdata;
    logic psel0, penable0, pready0, pslverr0;
    logic psel1, penable1, pready1, pslverr1;
    logic [31:0] prdata0, prdata1;

    int total = 0;
    int bad = 0;
    int cycles = 0;
    int wait_cfg [2] = '{0, 0};
    logic serr_cfg [2] = '{1'b0, 1'b0};
    int acc_cnt [2] = '{0, 0};
    logic in_flight = 1'b0;

    apb_item_t apb_q[$];
    rsp_item_t rsp_q[$];

    always #5 clk = ~clk;

    sysbus_to_pbus_bridge u_sysbus_to_pbus_bridge (
        .clk(clk), .rst_n(rst_n), .div_sel0(div_sel0), .div_sel1(div_sel1),
        .sys_valid(sys_valid), .sys_addr(sys_addr), .sys_write(sys_write),
        .sys_size(sys_size), .sys_wdata(sys_wdata), .sys_ready(sys_ready),
        .sys_done(sys_done), .sys_rdata(sys_rdata), .sys_err(sys_err),
        .paddr(paddr), .pwrite(pwrite), .pwdata(pwdata),
        .psel0(psel0), .penable0(penable0), .pready0(pready0),
        .prdata0(prdata0), .pslverr0(pslverr0),
        .psel1(psel1), .penable1(penable1), .pready1(pready1),
        .prdata1(prdata1), .pslverr1(pslverr1)
    );

    function automatic int ratio_of(input logic [2:0] sel);
        return 1 << ((sel > 3'd4) ? 4 : int'(sel));
    endfunction

    // Peripheral models
    always @(posedge clk) begin
        acc_cnt[0] <= (psel0 && penable0) ? acc_cnt[0] + 1 : 0;
        acc_cnt[1] <= (psel1 && penable1) ? acc_cnt[1] + 1 : 0;
    end

    always_comb begin
        pready0  = acc_cnt[0] >= wait_cfg[0] * ratio_of(div_sel0);
        pready1  = acc_cnt[1] >= wait_cfg[1] * ratio_of(div_sel1);
        prdata0  = {16'hC0DE, paddr};
        prdata1  = {16'hB1E5, paddr};
        pslverr0 = serr_cfg[0] && psel0 && penable0;
        pslverr1 = serr_cfg[1] && psel1 && penable1;
    end

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Driver: computes expectations and pushes them, then issues the request
    task automatic xfer(input logic wr, input logic [1:0] sz, input logic [31:0] addr,
                        input logic [31:0] wd, input int waits, input logic serr,
                        input string req);
        apb_item_t a;
        rsp_item_t r;
        int port;
        logic [7:0] b;
        logic [15:0] h;
        port = int'(addr[16]);
        b = wd[8*addr[1:0] +: 8];
        h = wd[16*addr[1] +: 16];
        a.port  = port;
        a.addr  = {addr[15:2], 2'b00};
        a.wr    = wr;
        a.wdata = (sz == 2'd0) ? {4{b}} : (sz == 2'd1) ? {2{h}} : wd;
        a.width = (waits + 2) * ratio_of(port ? div_sel1 : div_sel0);
        a.req   = req;
        r.rdata = wr ? 32'h0 : (port ? {16'hB1E5, a.addr} : {16'hC0DE, a.addr});
        r.err   = serr;
        r.req   = req;
        apb_q.push_back(a);
        rsp_q.push_back(r);
        wait_cfg[port] = waits;
        serr_cfg[port] = serr;
        @(negedge clk);
        sys_valid = 1'b1; sys_addr = addr; sys_write = wr; sys_size = sz; sys_wdata = wd;
        @(posedge clk);
        @(negedge clk);
        sys_valid = 1'b0;
        sys_wdata = 32'hDEAD_BEEF;
        in_flight = 1'b1;
        while (!sys_done) @(negedge clk);
        in_flight = 1'b0;
        @(negedge clk);
    endtask

    // Response monitor
    always @(negedge clk) begin
        if (rst_n && in_flight && !sys_done) chk("R6", "ready low while busy", 32'(sys_ready), 32'h0);
        if (rst_n && sys_done) begin
            chk("R6", "ready with done", 32'(sys_ready), 32'h1);
            if (rsp_q.size() == 0) begin
                chk("R6", "unexpected done", 32'h1, 32'h0);
            end else begin
                rsp_item_t r;
                r = rsp_q.pop_front();
                chk({r.req, "/R10"}, "rdata", sys_rdata, r.rdata);
                chk({r.req, "/R11"}, "err", 32'(sys_err), 32'(r.err));
            end
        end
    end

    // APB monitor
    logic prev_sel [2] = '{1'b0, 1'b0};
    int   width_cnt [2] = '{0, 0};
    int   exp_width [2] = '{0, 0};
    string cur_req [2] = '{"", ""};

    always @(negedge clk) begin
        logic s [2];
        logic e [2];
        s[0] = psel0; s[1] = psel1; e[0] = penable0; e[1] = penable1;
        if (rst_n) begin
            for (int p = 0; p < 2; p++) begin
                if (s[p] && !prev_sel[p]) begin
                    chk("R2", "other port select", 32'(s[1-p]), 32'h0);
                    chk("R3", "setup penable", 32'(e[p]), 32'h0);
                    if (apb_q.size() == 0) begin
                        chk("R2", "unexpected apb transfer", 32'h1, 32'h0);
                    end else begin
                        apb_item_t a;
                        a = apb_q.pop_front();
                        chk({a.req, "/R2"}, "port", 32'(p), 32'(a.port));
                        chk({a.req, "/R9"}, "paddr", 32'(paddr), 32'(a.addr));
                        chk(a.req, "pwrite", 32'(pwrite), 32'(a.wr));
                        if (a.wr) chk(a.req, "pwdata", pwdata, a.wdata);
                        exp_width[p] = a.width;
                        cur_req[p]   = a.req;
                    end
                    width_cnt[p] = 1;
                end else if (s[p]) begin
                    width_cnt[p] = width_cnt[p] + 1;
                end else if (prev_sel[p]) begin
                    chk({cur_req[p], "/R4/R5"}, "psel width", 32'(width_cnt[p]), 32'(exp_width[p]));
                end
                prev_sel[p] = s[p];
            end
        end
    end

    // Watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=%0d expected<=150000 cycles", cycles);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1", "ready in reset", 32'(sys_ready), 32'h1);
        chk("R1", "done in reset", 32'(sys_done), 32'h0);
        chk("R1", "selects in reset", {28'h0, psel1, penable1, psel0, penable0}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "idle after reset", {28'h0, psel1, penable1, psel0, sys_ready}, 32'h1);

        // Word writes, ratio 1 (R9, R4)
        xfer(1'b1, 2'd2, 32'h0000_0040, 32'h1234_5678, 0, 1'b0, "R9");
        xfer(1'b1, 2'd3, 32'h0000_0047, 32'hCAFE_F00D, 0, 1'b0, "R9");

        // Byte writes to all lanes, ratio 2 (R7)
        div_sel0 = 3'd1;
        xfer(1'b1, 2'd0, 32'h0000_0100, 32'h4433_2211, 0, 1'b0, "R7");
        xfer(1'b1, 2'd0, 32'h0000_0101, 32'h4433_2211, 0, 1'b0, "R7");
        xfer(1'b1, 2'd0, 32'h0000_0102, 32'h4433_2211, 1, 1'b0, "R7");
        xfer(1'b1, 2'd0, 32'h0000_0103, 32'h4433_2211, 0, 1'b0, "R7");

        // Halfword writes on port 1, ratio 4 (R8, R2)
        div_sel1 = 3'd2;
        xfer(1'b1, 2'd1, 32'h0001_0200, 32'hBBBB_AAAA, 0, 1'b0, "R8");
        xfer(1'b1, 2'd1, 32'h0001_0202, 32'hBBBB_AAAA, 0, 1'b0, "R8");

        // Reads with wait states (R10, R5)
        xfer(1'b0, 2'd2, 32'h0001_0310, 32'h0, 2, 1'b0, "R10");
        xfer(1'b0, 2'd0, 32'h0000_0323, 32'h0, 3, 1'b0, "R10");
        xfer(1'b0, 2'd1, 32'h0000_0332, 32'h0, 0, 1'b0, "R5");

        // Slave errors then clean transfers (R11)
        xfer(1'b1, 2'd2, 32'h0000_0400, 32'h0BAD_0BAD, 1, 1'b1, "R11");
        xfer(1'b1, 2'd2, 32'h0000_0404, 32'h600D_600D, 0, 1'b0, "R11");
        xfer(1'b0, 2'd2, 32'h0001_0408, 32'h0, 0, 1'b1, "R11");
        xfer(1'b0, 2'd2, 32'h0001_040C, 32'h0, 0, 1'b0, "R11");

        // Independent ratios, upper ratio and capped exponent (R12, R4)
        div_sel0 = 3'd3;
        div_sel1 = 3'd4;
        xfer(1'b1, 2'd2, 32'h0000_0500, 32'h0000_0505, 0, 1'b0, "R12");
        xfer(1'b1, 2'd2, 32'h0001_0500, 32'h0001_0505, 1, 1'b0, "R12");
        div_sel1 = 3'd7;
        xfer(1'b0, 2'd2, 32'h0001_0600, 32'h0, 1, 1'b0, "R4");
        div_sel0 = 3'd0;
        xfer(1'b1, 2'd0, 32'h0000_0702, 32'h00C3_0000, 0, 1'b0, "R12");

        repeat (4) @(negedge clk);
        chk("R2", "apb queue drained", 32'(apb_q.size()), 32'h0);
        chk("R6", "rsp queue drained", 32'(rsp_q.size()), 32'h0);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule